// File: doc/BRIEF.md
# Dual-Channel Timer Counter Unit

This block holds two independent 16-bit timer counters. Each channel picks its count tick from a shared power-of-two clock divider or from an external tick strobe. A run bit gates counting for the channel. A channel counts up in normal mode. In symmetric mode it counts up and down, turning round at full scale and at zero.

Each channel watches strobes for four general registers (named A to D), carrying both compare-match and capture events. Its clear-source field picks one of these registers, or none. An event on the picked register returns the counter to zero.

Each channel keeps sticky status flags: overflow on both channels, and underflow on channel 1 only. Software clears a flag by reading it as set and then writing a zero to it. Four output-level bits per channel drive the output pins directly.

Software reaches all of this through a small word-wide register bus. The bus has a write strobe, a read strobe, a channel select, a 2-bit register select, byte enables and a combinational read-data path.

Top module: `tcu_dual_timer`

## Requirements
- R1: After reset, both counters read 0x0000, the control words read 0 (channel stopped), the status flags read 0 and every pin output is low.
- R2: A counter write (select 0) loads all 16 bits only when both byte enables are set (bit 0 = low byte, bit 1 = high byte). A write with any other byte-enable pattern leaves the counter unchanged.
- R3: Control bits [2:0] pick the tick: a value k from 0 to 6 gives one count step per 2^k clocks, and 7 gives one step per clock on which the channel's external tick input is high. Control bit 7 (run) must be 1 for any step to happen.
- R4: With control bit 6 clear, the counter only increments. A step from 0xFFFF wraps to 0x0000 and sets overflow status bit 0.
- R5: Control bits [5:3] equal to 1, 2, 3 or 4 select register A, B, C or D. On the clock after a compare or capture strobe for the selected register (input bit ch*4 + 0..3 for A..D), the counter reads 0x0000, whether or not it is running. Strobes for other registers, or for the other channel, do not touch it.
- R6: A clear-source value of 0, or of 5 to 7, disables clearing. The counter is then unaffected by every strobe.
- R7: When a clear event and a full counter write arrive on the same clock, the counter reads 0x0000 afterwards.
- R8: With control bit 6 set, the counter steps up to 0xFFFF. The next step gives 0xFFFE, sets overflow and starts counting down. A step from 0x0000 gives 0x0001 and starts counting up again.
- R9: On channel 1, the down-to-up turn at zero sets underflow status bit 1. Channel 0 never sets status bit 1.
- R10: A status flag stays set until a status read has returned it as 1 and a later status write carries 0 in its bit. A zero written without a prior read, or a one written after a read, leaves it set.
- R11: Writing the level register (select 3) drives pin_o[ch*4+r] from data bit r on the next clock. Bits 3:0 of the written data are used and the rest are ignored. All pins reset low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_re | input | 1 | Register read strobe (arms status flag clearing) |
| bus_ch | input | 1 | Channel select |
| bus_sel | input | 2 | Register select: 0 counter, 1 control, 2 status, 3 level |
| bus_be | input | 2 | Byte enables of a write |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for the selected register |
| ext_tick | input | 2 | External count tick, one bit per channel |
| cmp_hit | input | 8 | Compare-match strobes, bit ch*4+r for register r (A..D) |
| cap_hit | input | 8 | Capture strobes, same bit layout |
| cnt_o | output | 32 | Counter values, channel ch in bits ch*16 +: 16 |
| pin_o | output | 8 | Output-level pins, bit ch*4+r |

## Verification
The bench drives the counter onto 0xFFFE, then onto 0xFFFF in symmetric mode, and onto zero while counting down. A design with an off-by-one turn point, or with a missing or misplaced underflow flag, would return the wrong counts or status word. It issues a clear strobe in the same cycle as a word write, so that a design with the wrong priority would keep the written value. It also sends strobes to unselected registers, to the other channel and under the no-clear encodings, so that an over-eager decoder would zero the counter. The status flags get a zero write with no prior read and a one write after a read. A flag clear that ignores the read handshake would drop the flag early.

// File: rtl/tcu_pkg.sv
package tcu_pkg;

  localparam int CW  = 16;
  localparam int NGR = 4;
  localparam int PSW = 3;

  typedef struct packed {
    logic       run;
    logic       sym;
    logic [2:0] clr;
    logic [2:0] psc;
  } ctrl_t;

  typedef enum logic [1:0] {
    SEL_CNT  = 2'd0,
    SEL_CTRL = 2'd1,
    SEL_STAT = 2'd2,
    SEL_LVL  = 2'd3
  } bsel_e;

endpackage

// File: rtl/tcu_prescaler.sv
module tcu_prescaler #(
  parameter int STAGES = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [STAGES:0]   tick_o
);

  logic [STAGES-1:0] div_q;
  logic [STAGES-1:0] div_d;

  always_comb begin
    div_d = div_q + STAGES'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_d;
  end

  assign tick_o[0] = 1'b1;

  for (genvar k = 1; k <= STAGES; k++) begin : g_tap
    assign tick_o[k] = &div_q[k-1:0];
  end

  // R3
  div2_alt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o[1] |=> !tick_o[1]);

endmodule

// File: rtl/tcu_flag.sv
module tcu_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic rd_i,
  input  logic wr_i,
  input  logic wbit_i,
  output logic flag_o
);

  logic flag_q, flag_d;
  logic arm_q, arm_d;
  logic clr;

  always_comb begin
    arm_d = arm_q;
    if (wr_i)      arm_d = 1'b0;
    else if (rd_i) arm_d = flag_q;
    clr    = wr_i & arm_q & ~wbit_i;
    flag_d = set_i | (flag_q & ~clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      arm_q  <= 1'b0;
    end else begin
      flag_q <= flag_d;
      arm_q  <= arm_d;
    end
  end

  assign flag_o = flag_q;

  // R4
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> flag_o);

  // R10
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_o && !wr_i) |=> flag_o);

  // R10
  flag_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag_o && !set_i) |=> !flag_o);

endmodule

// File: rtl/tcu_channel.sv
module tcu_channel
  import tcu_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int NREG    = 4,
  parameter int NDIV    = 7,
  parameter int HAS_UDF = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NDIV-1:0]   div_tick_i,
  input  logic              ext_tick_i,
  input  logic [NREG-1:0]   cmp_hit_i,
  input  logic [NREG-1:0]   cap_hit_i,
  input  logic              cnt_wr_i,
  input  logic              cnt_full_i,
  input  logic              ctrl_wr_i,
  input  logic              lvl_wr_i,
  input  logic              stat_rd_i,
  input  logic              stat_wr_i,
  input  logic [CNT_W-1:0]  wdata_i,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [7:0]        ctrl_o,
  output logic [1:0]        stat_o,
  output logic [NREG-1:0]   lvl_o
);

  localparam logic [CNT_W-1:0] TOP    = {CNT_W{1'b1}};
  localparam logic             UDF_EN = (HAS_UDF != 0);

  ctrl_t             ctrl_q;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              down_q, down_d;
  logic              cnt_en;
  logic [NREG-1:0]   lvl_q;
  logic [NDIV:0]     src;
  logic              tick, step, clr_hit, wr_acc;
  logic              ovf_set, udf_evt, udf_set;

  assign src  = {ext_tick_i, div_tick_i};
  assign tick = src[ctrl_q.psc];
  assign step = ctrl_q.run & tick;
  assign wr_acc = cnt_wr_i & cnt_full_i;

  always_comb begin
    clr_hit = 1'b0;
    for (int r = 0; r < NREG; r++) begin
      if (ctrl_q.clr == 3'(r + 1)) clr_hit = cmp_hit_i[r] | cap_hit_i[r];
    end
  end

  always_comb begin
    cnt_d   = cnt_q;
    down_d  = down_q;
    cnt_en  = 1'b0;
    ovf_set = 1'b0;
    udf_evt = 1'b0;
    if (clr_hit) begin
      cnt_d  = '0;
      down_d = 1'b0;
      cnt_en = 1'b1;
    end else if (wr_acc) begin
      cnt_d  = wdata_i;
      cnt_en = 1'b1;
    end else if (step) begin
      cnt_en = 1'b1;
      if (!ctrl_q.sym) begin
        cnt_d   = cnt_q + CNT_W'(1);
        down_d  = 1'b0;
        ovf_set = (cnt_q == TOP);
      end else if (!down_q) begin
        if (cnt_q == TOP) begin
          cnt_d   = TOP - CNT_W'(1);
          down_d  = 1'b1;
          ovf_set = 1'b1;
        end else begin
          cnt_d = cnt_q + CNT_W'(1);
        end
      end else begin
        if (cnt_q == '0) begin
          cnt_d   = CNT_W'(1);
          down_d  = 1'b0;
          udf_evt = 1'b1;
        end else begin
          cnt_d = cnt_q - CNT_W'(1);
        end
      end
    end
  end

  assign udf_set = udf_evt & UDF_EN;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      down_q <= 1'b0;
    end else if (cnt_en) begin
      cnt_q  <= cnt_d;
      down_q <= down_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         ctrl_q <= '0;
    else if (ctrl_wr_i) ctrl_q <= ctrl_t'(wdata_i[7:0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        lvl_q <= '0;
    else if (lvl_wr_i) lvl_q <= wdata_i[NREG-1:0];
  end

  tcu_flag u_ovf (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (ovf_set),
    .rd_i   (stat_rd_i),
    .wr_i   (stat_wr_i),
    .wbit_i (wdata_i[0]),
    .flag_o (stat_o[0])
  );

  tcu_flag u_udf (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (udf_set),
    .rd_i   (stat_rd_i),
    .wr_i   (stat_wr_i),
    .wbit_i (wdata_i[1]),
    .flag_o (stat_o[1])
  );

  assign cnt_o  = cnt_q;
  assign ctrl_o = ctrl_q;
  assign lvl_o  = lvl_q;

  // R5
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_hit |=> (cnt_o == '0));

  // R7
  clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_hit && cnt_wr_i) |=> (cnt_o == '0));

  // R2
  part_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_wr_i && !cnt_full_i && !step && !clr_hit) |=> $stable(cnt_o));

  // R4
  up_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !ctrl_o[6] && !clr_hit && !wr_acc) |=> (cnt_o == $past(cnt_o) + CNT_W'(1)));

  // R11
  level_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_wr_i |=> (lvl_o == $past(wdata_i[NREG-1:0])));

endmodule

// File: rtl/tcu_dual_timer.sv
module tcu_dual_timer
  import tcu_pkg::*;
#(
  parameter int NCH    = 2,
  parameter int UDF_CH = 1,
  localparam int CHW   = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int NDIV  = (1 << PSW) - 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_we,
  input  logic                 bus_re,
  input  logic [CHW-1:0]       bus_ch,
  input  logic [1:0]           bus_sel,
  input  logic [1:0]           bus_be,
  input  logic [CW-1:0]        bus_wdata,
  output logic [CW-1:0]        bus_rdata,
  input  logic [NCH-1:0]       ext_tick,
  input  logic [NCH*NGR-1:0]   cmp_hit,
  input  logic [NCH*NGR-1:0]   cap_hit,
  output logic [NCH*CW-1:0]    cnt_o,
  output logic [NCH*NGR-1:0]   pin_o
);

  logic             rs_q1, rs_q2;
  logic [NDIV-1:0]  div_tick;
  logic             full_word;

  logic [CW-1:0]    cnt_a  [NCH];
  logic [7:0]       ctrl_a [NCH];
  logic [1:0]       stat_a [NCH];
  logic [NGR-1:0]   lvl_a  [NCH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_q1 <= 1'b0;
      rs_q2 <= 1'b0;
    end else begin
      rs_q1 <= 1'b1;
      rs_q2 <= rs_q1;
    end
  end

  tcu_prescaler #(.STAGES(NDIV - 1)) u_psc (
    .clk    (clk),
    .rst_n  (rs_q2),
    .tick_o (div_tick)
  );

  assign full_word = &bus_be;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic hit;
    assign hit = (bus_ch == CHW'(g));

    tcu_channel #(
      .CNT_W   (CW),
      .NREG    (NGR),
      .NDIV    (NDIV),
      .HAS_UDF ((g == UDF_CH) ? 1 : 0)
    ) u_chan (
      .clk        (clk),
      .rst_n      (rs_q2),
      .div_tick_i (div_tick),
      .ext_tick_i (ext_tick[g]),
      .cmp_hit_i  (cmp_hit[g*NGR +: NGR]),
      .cap_hit_i  (cap_hit[g*NGR +: NGR]),
      .cnt_wr_i   (bus_we & hit & (bus_sel == SEL_CNT)),
      .cnt_full_i (full_word),
      .ctrl_wr_i  (bus_we & hit & (bus_sel == SEL_CTRL)),
      .lvl_wr_i   (bus_we & hit & (bus_sel == SEL_LVL)),
      .stat_rd_i  (bus_re & hit & (bus_sel == SEL_STAT)),
      .stat_wr_i  (bus_we & hit & (bus_sel == SEL_STAT)),
      .wdata_i    (bus_wdata),
      .cnt_o      (cnt_a[g]),
      .ctrl_o     (ctrl_a[g]),
      .stat_o     (stat_a[g]),
      .lvl_o      (lvl_a[g])
    );

    assign cnt_o[g*CW +: CW]  = cnt_a[g];
    assign pin_o[g*NGR +: NGR] = lvl_a[g];
  end

  always_comb begin
    bus_rdata = '0;
    case (bsel_e'(bus_sel))
      SEL_CNT:  bus_rdata = cnt_a[bus_ch];
      SEL_CTRL: bus_rdata = CW'(ctrl_a[bus_ch]);
      SEL_STAT: bus_rdata = CW'(stat_a[bus_ch]);
      default:  bus_rdata = CW'(lvl_a[bus_ch]);
    endcase
  end

  // R1
  reset_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rs_q2 |=> (cnt_o == '0 && pin_o == '0));

endmodule

// File: tb/tcu_dual_timer_tb.sv
`timescale 1ns/1ps
module tcu_dual_timer_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_we, bus_re;
  logic [0:0]  bus_ch;
  logic [1:0]  bus_sel, bus_be;
  logic [15:0] bus_wdata, bus_rdata;
  logic [1:0]  ext_tick;
  logic [7:0]  cmp_hit, cap_hit, pin_o;
  logic [31:0] cnt_o;

  always #10 clk = ~clk;

  tcu_dual_timer u_dut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_re(bus_re),
    .bus_ch(bus_ch), .bus_sel(bus_sel), .bus_be(bus_be),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ext_tick(ext_tick),
    .cmp_hit(cmp_hit), .cap_hit(cap_hit), .cnt_o(cnt_o), .pin_o(pin_o)
  );

  typedef struct {
    int          req;
    int          what;
    logic [15:0] exp;
  } item_t;

  item_t sb[$];
  int    checks = 0;
  int    fails  = 0;
  bit    done   = 0;

  // monitor: pops expected items and compares them against the ports
  initial begin
    forever begin
      @(negedge clk);
      while (sb.size() > 0) begin
        item_t       it;
        logic [15:0] act;
        it = sb.pop_front();
        case (it.what)
          0:       act = cnt_o[15:0];
          1:       act = cnt_o[31:16];
          2:       act = {8'h00, pin_o};
          default: act = bus_rdata;
        endcase
        checks++;
        if (act !== it.exp) begin
          fails++;
          $display("FAIL R%0d: item %0d got %h expected %h", it.req, it.what, act, it.exp);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic expect_item(input int req, input int what, input logic [15:0] e);
    item_t it;
    it.req = req; it.what = what; it.exp = e;
    sb.push_back(it);
  endtask

  task automatic bwr(input int ch, input int sel, input logic [1:0] be, input logic [15:0] d);
    @(negedge clk); #1;
    bus_we = 1'b1; bus_ch = 1'(ch); bus_sel = 2'(sel); bus_be = be; bus_wdata = d;
    @(posedge clk); #1;
    bus_we = 1'b0;
  endtask

  task automatic brd(input int ch, input int sel);
    @(negedge clk); #1;
    bus_re = 1'b1; bus_ch = 1'(ch); bus_sel = 2'(sel);
    @(posedge clk); #1;
    bus_re = 1'b0;
  endtask

  task automatic pulse(input logic [7:0] cm, input logic [7:0] cp, input logic [1:0] ex);
    @(negedge clk); #1;
    cmp_hit = cm; cap_hit = cp; ext_tick = ex;
    @(posedge clk); #1;
    cmp_hit = '0; cap_hit = '0; ext_tick = '0;
  endtask

  task automatic wr_and_clear(input logic [15:0] d, input logic [7:0] cm);
    @(negedge clk); #1;
    bus_we = 1'b1; bus_ch = 1'b0; bus_sel = 2'd0; bus_be = 2'b11; bus_wdata = d; cmp_hit = cm;
    @(posedge clk); #1;
    bus_we = 1'b0; cmp_hit = '0;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // R3: one step per 2^k clocks over a window of m*2^k clocks
  task automatic presc_case(input int k, input int m);
    bwr(0, 1, 2'b11, 16'h0000);
    bwr(0, 0, 2'b11, 16'h0000);
    bwr(0, 1, 2'b11, 16'(8'h80 | k));
    wait_cyc(m << k);
    expect_item(3, 0, 16'(m));
  endtask

  initial begin
    rst_n = 1'b0; bus_we = 0; bus_re = 0; bus_ch = 0; bus_sel = 0; bus_be = 0;
    bus_wdata = 0; ext_tick = 0; cmp_hit = 0; cap_hit = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    wait_cyc(4);

    // R1 reset state
    expect_item(1, 0, 16'h0000);
    expect_item(1, 1, 16'h0000);
    expect_item(1, 2, 16'h0000);
    brd(0, 1); expect_item(1, 3, 16'h0000);
    brd(1, 2); expect_item(1, 3, 16'h0000);

    // R2 full-word write loads, partial writes ignored
    bwr(0, 0, 2'b11, 16'h1234); expect_item(2, 0, 16'h1234);
    bwr(0, 0, 2'b01, 16'hABCD); expect_item(2, 0, 16'h1234);
    bwr(0, 0, 2'b10, 16'hABCD); expect_item(2, 0, 16'h1234);
    bwr(0, 0, 2'b00, 16'hABCD); expect_item(2, 0, 16'h1234);

    // R3 tick selection
    presc_case(0, 5);
    presc_case(2, 3);
    presc_case(6, 2);
    bwr(0, 1, 2'b11, 16'h0000);
    bwr(0, 0, 2'b11, 16'h0000);
    bwr(0, 1, 2'b11, 16'h0087);
    wait_cyc(10);
    expect_item(3, 0, 16'h0000);          // R3 external source, no tick
    pulse(8'h00, 8'h00, 2'b10);           // other channel's tick only
    pulse(8'h00, 8'h00, 2'b01);
    pulse(8'h00, 8'h00, 2'b01);
    pulse(8'h00, 8'h00, 2'b01);
    expect_item(3, 0, 16'h0003);
    bwr(0, 1, 2'b11, 16'h0000);           // R3 run bit off
    wait_cyc(5);
    expect_item(3, 0, 16'h0003);

    // R4 up count wraps and sets overflow
    bwr(0, 0, 2'b11, 16'hFFFE);
    bwr(0, 1, 2'b11, 16'h0080);
    wait_cyc(2);
    expect_item(4, 0, 16'h0000);
    bwr(0, 1, 2'b11, 16'h0000);

    // R10 flag clear handshake
    bwr(0, 2, 2'b11, 16'h0000);           // zero without prior read
    brd(0, 2); expect_item(10, 3, 16'h0001);
    bwr(0, 2, 2'b11, 16'h0001);           // one after read
    brd(0, 2); expect_item(10, 3, 16'h0001);
    bwr(0, 2, 2'b11, 16'h0000);           // zero after read
    brd(0, 2); expect_item(10, 3, 16'h0000);

    // R5 clear on selected register
    bwr(0, 1, 2'b11, 16'h0010);           // clear source B
    bwr(0, 0, 2'b11, 16'h0055);
    pulse(8'h01, 8'h00, 2'b00);           // A: ignored
    expect_item(5, 0, 16'h0055);
    pulse(8'h02, 8'h00, 2'b00);           // B compare
    expect_item(5, 0, 16'h0000);
    bwr(0, 1, 2'b11, 16'h0020);           // clear source D
    bwr(0, 0, 2'b11, 16'h0066);
    pulse(8'h00, 8'h80, 2'b00);           // other channel's D capture
    expect_item(5, 0, 16'h0066);
    pulse(8'h00, 8'h08, 2'b00);           // D capture
    expect_item(5, 0, 16'h0000);

    // R6 no clearing
    bwr(0, 1, 2'b11, 16'h0000);
    bwr(0, 0, 2'b11, 16'h0099);
    pulse(8'h0F, 8'h0F, 2'b00);
    expect_item(6, 0, 16'h0099);
    bwr(0, 1, 2'b11, 16'h0038);
    pulse(8'h0F, 8'h0F, 2'b00);
    expect_item(6, 0, 16'h0099);

    // R7 clear beats write
    bwr(0, 1, 2'b11, 16'h0008);
    wr_and_clear(16'h4444, 8'h01);
    expect_item(7, 0, 16'h0000);

    // R8 / R9 symmetric mode on channel 1
    bwr(1, 0, 2'b11, 16'hFFFD);
    bwr(1, 1, 2'b11, 16'h00C0);
    wait_cyc(3);
    expect_item(8, 1, 16'hFFFE);
    wait_cyc(1);
    expect_item(8, 1, 16'hFFFD);
    bwr(1, 0, 2'b11, 16'h0002);
    expect_item(8, 1, 16'h0002);
    wait_cyc(3);
    expect_item(8, 1, 16'h0001);
    wait_cyc(1);
    expect_item(8, 1, 16'h0002);
    bwr(1, 1, 2'b11, 16'h0000);
    brd(1, 2); expect_item(9, 3, 16'h0003);

    // R9 channel 0 turn at zero gives no underflow
    bwr(0, 1, 2'b11, 16'h0000);
    bwr(0, 0, 2'b11, 16'hFFFF);
    bwr(0, 1, 2'b11, 16'h00C0);
    wait_cyc(1);
    expect_item(8, 0, 16'hFFFE);
    bwr(0, 0, 2'b11, 16'h0001);
    wait_cyc(2);
    expect_item(8, 0, 16'h0001);
    bwr(0, 1, 2'b11, 16'h0000);
    brd(0, 2); expect_item(9, 3, 16'h0001);

    // R11 level pins
    bwr(0, 3, 2'b11, 16'h000A); expect_item(11, 2, 16'h000A);
    bwr(1, 3, 2'b11, 16'hFFF5); expect_item(11, 2, 16'h005A);
    bwr(0, 3, 2'b11, 16'h0000); expect_item(11, 2, 16'h0050);

    @(negedge clk); #1;
    @(negedge clk); #1;
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule